// File: doc/BRIEF.md
# Deadlock Watchdog Timer with Shared Prescaled Counter

This block guards a controlling state machine against deadlock. The supervised machine kicks the timer when it leaves its idle state and aborts it when its work finishes. If the work does not finish before the selected delay runs out, the block raises a one-cycle timeout pulse. The supervised machine uses that pulse to force itself back to IDLE.

All delays are given as real-valued seconds, together with the clock frequency in hertz and the length of one prescaler tick in seconds. The terminal counts are computed from these values when the design is elaborated, so no hand-entered count appears anywhere. A prescaler divides the clock down to a single-cycle enable tick. One main counter counts those ticks and is shared by four selectable delays. Only one delay runs at a time. Both counter widths come from a ceiling log2 of the largest computed count. This lets delays of several seconds at full clock rate use counters of modest width, with no overflow.

Top module: `wdt_timeout`

## Requirements
- R1: The reset input `rst_n` is synchronous and active low. On the first rising clock edge at which it is sampled low, `busy` and `timeout` both go low, and they stay low while it is held.
- R2: When `kick` is sampled high and `abort` is low, `busy` is high from the next cycle on, both counters start from zero, and the value on `dly_sel` is latched.
- R3: The prescaler period is P = round(CLK_HZ × TICK_S) cycles. The latched select k (0 to 3) picks N = round(DLYk_S / TICK_S) ticks. `timeout` is high in exactly the cycle that follows the N×P-th rising edge after the edge that sampled the kick.
- R4: `timeout` is high for exactly one cycle, and `busy` is low in that same cycle.
- R5: A kick while `busy` is high restarts the timing from zero, using the select value present at that kick.
- R6: When `abort` is sampled high, `busy` is low from the next cycle and no timeout pulse follows. `abort` takes priority over a simultaneous `kick`.
- R7: Changes on `dly_sel` while the timer is busy have no effect on when the timeout occurs.
- R8: The counter widths are ceil(log2) of their largest terminal count. Neither counter ever exceeds its terminal count minus one.
- R9: The prescaler emits its enable tick only while busy, and the main counter advances only on that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| kick | input | 1 | Start, or restart, the timer with the current select |
| abort | input | 1 | Stop the timer without a timeout |
| dly_sel | input | 2 | Index of the delay to use, latched on kick |
| timeout | output | 1 | One-cycle pulse when the delay expires |
| busy | output | 1 | High while a delay is being timed |

## Verification
The checker treats `kick` and `abort` as ordinary synchronous inputs. It relies on the stated priority of abort over kick and assumes no other relation between them. The stimulus drives every input on the falling edge, one change at a time. It includes a kick and an abort in the same cycle, so the priority case is exercised directly. The bench never lets an abort or a re-kick land on the edge that would produce the timeout, so every expected timeout cycle is unambiguous. The bench uses small default delays so that each run of every select fits in a few thousand cycles.

// File: rtl/wdt_pkg.sv
// Package: shared helpers for the watchdog timer.
// Assumes real-valued parameters are positive. Every computed count is at least one.
package wdt_pkg;

    localparam int NUM_SEL = 4;
    localparam int SEL_W   = 2;

    // Round a positive real ratio to the nearest integer, never below one.
    function automatic int ratio_count(input real num, input real den);
        int r;
        r = $rtoi(num / den + 0.5);
        return (r < 1) ? 1 : r;
    endfunction

    // Bits needed to hold the values 0 to tc-1, never below one.
    function automatic int cnt_width(input int tc);
        return (tc <= 2) ? 1 : $clog2(tc);
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
// Prescaler: divides the clock by TC and emits a single-cycle enable tick.
// Counts only while run is high. clr restarts the count from zero.
module wdt_prescaler #(
    parameter int TC = 20,
    localparam int W = wdt_pkg::cnt_width(TC)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    output logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LAST = W'(TC - 1);

    // Tick on the last count of each period, but only while running.
    assign tick = run && (cnt == LAST);

    // Period counter: wraps at TC-1 and holds zero when idle or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdt_tc_table.sv
// Terminal-count table: converts each real delay into a tick count and
// returns the count for the selected index, minus one, as a compare value.
// Assumes every delay is at least one tick long.
module wdt_tc_table #(
    parameter real TICK_S = 0.1e-6,
    parameter real DLY0_S = 1.0e-6,
    parameter real DLY1_S = 2.5e-6,
    parameter real DLY2_S = 5.0e-6,
    parameter real DLY3_S = 12.0e-6,
    parameter int  W      = 7
) (
    input  logic [wdt_pkg::SEL_W-1:0] sel,
    output logic [W-1:0]              last
);
    localparam int TC [wdt_pkg::NUM_SEL] = '{
        wdt_pkg::ratio_count(DLY0_S, TICK_S),
        wdt_pkg::ratio_count(DLY1_S, TICK_S),
        wdt_pkg::ratio_count(DLY2_S, TICK_S),
        wdt_pkg::ratio_count(DLY3_S, TICK_S)
    };

    logic [W-1:0] entry [wdt_pkg::NUM_SEL];

    // One constant compare value per selectable delay.
    for (genvar g = 0; g < wdt_pkg::NUM_SEL; g++) begin : g_entry
        assign entry[g] = W'(TC[g] - 1);
    end

    // Select the compare value for the requested delay.
    assign last = entry[sel];
endmodule

// File: rtl/wdt_main_ctr.sv
// Main tick counter with control: starts on kick, stops on abort, and raises
// a one-cycle timeout once the latched number of ticks has elapsed.
// Assumes tick is a single-cycle enable. Abort has priority over kick.
module wdt_main_ctr #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         kick,
    input  logic         abort,
    input  logic         tick,
    input  logic [W-1:0] sel_last,
    output logic         busy,
    output logic         timeout,
    output logic [W-1:0] cnt
);
    logic [W-1:0] last_q;

    // Control and counting: reset, abort, kick, then tick-driven advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            timeout <= 1'b0;
            cnt     <= '0;
            last_q  <= '0;
        end else if (abort) begin
            busy    <= 1'b0;
            timeout <= 1'b0;
            cnt     <= '0;
        end else if (kick) begin
            busy    <= 1'b1;
            timeout <= 1'b0;
            cnt     <= '0;
            last_q  <= sel_last;
        end else begin
            timeout <= 1'b0;
            if (busy && tick) begin
                if (cnt == last_q) begin
                    busy    <= 1'b0;
                    timeout <= 1'b1;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdt_timeout.sv
// Watchdog timeout top: derives the prescaler and delay counts from the
// clock frequency and real delays, and wires the prescaler to the shared
// main counter. Assumes a single clock domain and synchronous inputs.
module wdt_timeout #(
    parameter real CLK_HZ = 200.0e6,
    parameter real TICK_S = 0.1e-6,
    parameter real DLY0_S = 1.0e-6,
    parameter real DLY1_S = 2.5e-6,
    parameter real DLY2_S = 5.0e-6,
    parameter real DLY3_S = 12.0e-6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick,
    input  logic       abort,
    input  logic [1:0] dly_sel,
    output logic       timeout,
    output logic       busy
);
    localparam int PRE_TC = wdt_pkg::ratio_count(CLK_HZ * TICK_S, 1.0);
    localparam int TC0 = wdt_pkg::ratio_count(DLY0_S, TICK_S);
    localparam int TC1 = wdt_pkg::ratio_count(DLY1_S, TICK_S);
    localparam int TC2 = wdt_pkg::ratio_count(DLY2_S, TICK_S);
    localparam int TC3 = wdt_pkg::ratio_count(DLY3_S, TICK_S);
    localparam int MAX01  = (TC0 > TC1) ? TC0 : TC1;
    localparam int MAX23  = (TC2 > TC3) ? TC2 : TC3;
    localparam int MAX_TC = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int PRE_W  = wdt_pkg::cnt_width(PRE_TC);
    localparam int MAIN_W = wdt_pkg::cnt_width(MAX_TC);

    logic              tick;
    logic [PRE_W-1:0]  pre_cnt;
    logic [MAIN_W-1:0] main_cnt;
    logic [MAIN_W-1:0] sel_last;

    wdt_prescaler #(.TC(PRE_TC)) pre_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (kick || abort),
        .run  (busy),
        .tick (tick),
        .cnt  (pre_cnt)
    );

    wdt_tc_table #(
        .TICK_S(TICK_S), .DLY0_S(DLY0_S), .DLY1_S(DLY1_S),
        .DLY2_S(DLY2_S), .DLY3_S(DLY3_S), .W(MAIN_W)
    ) tbl_i (
        .sel (dly_sel),
        .last(sel_last)
    );

    wdt_main_ctr #(.W(MAIN_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (kick),
        .abort   (abort),
        .tick    (tick),
        .sel_last(sel_last),
        .busy    (busy),
        .timeout (timeout),
        .cnt     (main_cnt)
    );
endmodule

// File: rtl/wdt_timeout_chk.sv
// Checker: temporal properties of the watchdog, bound into wdt_timeout.
// Assumes inputs change only between clock edges.
module wdt_timeout_chk #(
    parameter int PRE_TC = 20,
    parameter int MAX_TC = 120,
    parameter int PRE_W  = 5,
    parameter int MAIN_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kick,
    input logic              abort,
    input logic              timeout,
    input logic              busy,
    input logic              tick,
    input logic [PRE_W-1:0]  pre_cnt,
    input logic [MAIN_W-1:0] main_cnt
);
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        kick && !abort |=> busy && !timeout && main_cnt == '0);

    p_from_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(busy));

    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    p_idle_on_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !busy);

    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy && !timeout);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pre_cnt) < PRE_TC && int'(main_cnt) < MAX_TC);

    p_tick_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> busy);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !tick && !kick && !abort |=> $stable(main_cnt));
endmodule

bind wdt_timeout wdt_timeout_chk #(
    .PRE_TC(PRE_TC), .MAX_TC(MAX_TC), .PRE_W(PRE_W), .MAIN_W(MAIN_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .kick(kick), .abort(abort),
    .timeout(timeout), .busy(busy), .tick(tick),
    .pre_cnt(pre_cnt), .main_cnt(main_cnt)
);

// File: tb/wdt_timeout_tb_top.sv
// Scoreboard bench: driver tasks queue the expected timeout cycle; a monitor
// compares timeout and busy against the queue on every cycle.
module wdt_timeout_tb_top;
    localparam real CLK_HZ = 200.0e6;
    localparam real TICK_S = 0.1e-6;
    localparam real DLY_S [4] = '{1.0e-6, 2.5e-6, 5.0e-6, 12.0e-6};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kick = 1'b0;
    logic       abort = 1'b0;
    logic [1:0] dly_sel = 2'd0;
    logic       timeout;
    logic       busy;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_q [$];
    bit done = 1'b0;

    wdt_timeout #(
        .CLK_HZ(CLK_HZ), .TICK_S(TICK_S),
        .DLY0_S(DLY_S[0]), .DLY1_S(DLY_S[1]),
        .DLY2_S(DLY_S[2]), .DLY3_S(DLY_S[3])
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .kick(kick), .abort(abort),
        .dly_sel(dly_sel), .timeout(timeout), .busy(busy)
    );

    always #2.5 clk = ~clk;

    // Expected delay in clock cycles for a select value (the R3 formula).
    function automatic int span(input int s);
        int p, n;
        p = $rtoi(CLK_HZ * TICK_S + 0.5);
        n = $rtoi(DLY_S[s] / TICK_S + 0.5);
        return p * n;
    endfunction

    // Monitor: one comparison per cycle, just after the rising edge.
    always begin
        @(posedge clk);
        #1;
        cyc++;
        if (rst_n) begin
            if (exp_q.size() != 0 && exp_q[0] == cyc) begin
                total++;
                if (timeout !== 1'b1 || busy !== 1'b0) begin
                    bad++;
                    $display("FAIL R3 R4 R8 R9: cycle %0d timeout=%b busy=%b expected timeout=1 busy=0",
                             cyc, timeout, busy);
                end
                void'(exp_q.pop_front());
            end else begin
                total++;
                if (timeout !== 1'b0 || busy !== (exp_q.size() != 0)) begin
                    bad++;
                    $display("FAIL R2 R5 R6 R7: cycle %0d timeout=%b busy=%b expected timeout=0 busy=%b",
                             cyc, timeout, busy, exp_q.size() != 0);
                end
            end
        end else begin
            total++;
            if (timeout !== 1'b0 || busy !== 1'b0) begin
                bad++;
                $display("FAIL R1: cycle %0d timeout=%b busy=%b expected 0 0", cyc, timeout, busy);
            end
        end
    end

    task automatic do_kick(input int s);
        @(negedge clk);
        dly_sel = 2'(s);
        kick = 1'b1;
        exp_q.delete();
        exp_q.push_back(cyc + 1 + span(s));
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic do_abort();
        @(negedge clk);
        abort = 1'b1;
        exp_q.delete();
        @(negedge clk);
        abort = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        wait_cycles(5);
    endtask

    // Driver: the test sequence.
    initial begin
        wait_cycles(4);             // R1: reset held low
        @(negedge clk) rst_n = 1'b1;
        wait_cycles(2);
        // R3: each select times out after its own span
        for (int s = 0; s < 4; s++) begin
            do_kick(s);
            wait_idle();
        end
        // R7: select changes while busy are ignored
        do_kick(3);
        wait_cycles(300);
        @(negedge clk) dly_sel = 2'd0;
        wait_idle();
        // R5: re-kick while busy restarts with the new select
        do_kick(1);
        wait_cycles(200);
        do_kick(0);
        wait_idle();
        // R6: abort mid-run gives no pulse
        do_kick(2);
        wait_cycles(300);
        do_abort();
        wait_cycles(1200);
        // R6: abort beats a simultaneous kick
        @(negedge clk);
        kick = 1'b1;
        abort = 1'b1;
        exp_q.delete();
        @(negedge clk);
        kick = 1'b0;
        abort = 1'b0;
        wait_cycles(300);
        // R1: reset mid-run clears the timer
        do_kick(2);
        wait_cycles(100);
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        wait_cycles(3);
        @(negedge clk) rst_n = 1'b1;
        wait_cycles(1200);
        // R3 again after reset
        do_kick(0);
        wait_idle();
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule